// File: doc/BRIEF.md
# DMA Queue Descriptor Ring Controller

This block runs one queue of a multichannel DMA engine whose descriptors live in a ring in host memory. Software programs the ring base, the ring size, a 64-bit host address that receives the consumed-head index, and a batching delay. It then sets the enable bits in the control register and rings a doorbell by writing a new tail index. The controller walks its fetch index toward the tail. For each ring slot it issues one descriptor fetch request whose address is the base plus 32 bytes per slot.

The completion logic reports finished descriptors on a valid/ready port. Each completion carries that descriptor's interrupt flag and writeback flag. Every accepted completion advances the consumed head. An interrupt request pulses when both the queue-level enable and the descriptor flag allow it. Head writebacks are merged over a programmable number of cycles, and only the latest head goes out. A merge window is cut short as soon as the ring drains. Writing the queue-reset register returns the queue to its idle state.

The register port is a single-cycle write strobe with address and data. Reads are a combinational decode of a separate read address.

Top module: `desc_ring_ctl`

## Requirements
- R1: After reset, every queue register reads 0, and fetchValid, wbValid and irqReq are low.
- R2: Registers sit at these byte offsets: control 0x00 (bit0 queue enable, bit1 writeback enable, bit2 interrupt enable), ring base low 0x08 and high 0x0C, ring size in entries 0x10, tail 0x14, writeback address low 0x20 and high 0x24, batch delay 0x28, payload count 0x44, queue reset 0x48. Each register reads back what was last written to it.
- R3: While the queue is enabled and the fetch index differs from the tail, fetchValid is high and fetchAddr equals base + 32 × index. Each handshake advances the index by one, modulo the ring size, which is a power of two. If the low 8 bits of the ring size are zero, the ring has 256 entries.
- R4: While control bit0 is 0, no fetch is requested. A tail written in that state is kept and is served once the queue is enabled.
- R5: Each accepted completion advances the consumed head modulo the ring size. cplReady is low while a writeback is outstanding or is being launched.
- R6: irqReq pulses for one cycle after an accepted completion when control bit2 and the descriptor's interrupt flag are both 1.
- R7: A completion whose writeback flag is 1, with control bit1 set, leads to a writeback request. The request carries wbAddr = {high, low} and the head index, and it holds until wbReady.
- R8: With batch delay D, the writeback starts on the (D+1)th clock edge after the completion that opened the batch. Later completions merge into it, and only the newest head index is sent.
- R9: When the consumed head equals the tail while a writeback is pending, it is sent on the next edge, whatever the delay.
- R10: ringFull is 1 exactly when (tail + 1) modulo the ring size equals the consumed head.
- R11: Writing 1 to bit0 of the queue-reset register clears head, tail, fetch index, pending writeback and the control bits. The register then reads 1 for one cycle and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Write byte offset |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 8 | Read byte offset |
| regRdData | output | 32 | Read data |
| fetchValid | output | 1 | Descriptor fetch request valid |
| fetchReady | input | 1 | Fetch request accepted |
| fetchAddr | output | 64 | Host address of the descriptor |
| cplValid | input | 1 | Descriptor completion valid |
| cplReady | output | 1 | Completion accepted |
| cplIrqEn | input | 1 | Descriptor interrupt flag |
| cplWbEn | input | 1 | Descriptor writeback flag |
| irqReq | output | 1 | Interrupt request pulse |
| wbValid | output | 1 | Head writeback request valid |
| wbReady | input | 1 | Writeback accepted |
| wbAddr | output | 64 | Host address for the head writeback |
| wbData | output | IDX_W | Consumed head index written back |
| ringFull | output | 1 | Ring full indication |

## Verification
A new completion and the launch of a merged writeback can fall in the same cycle. The launch wins: cplReady drops in that cycle, so the head that goes out is never the one being updated. The bench holds cplValid high across batch windows and through the drain moment to provoke this collision. A per-clock reference model then judges cplReady, wbValid and wbData. The same model also covers a queue-reset write that lands while a fetch handshake is offered, and checks that the fetch is withdrawn.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_BASEL = 8'h08;
  localparam logic [REG_AW-1:0] OFS_BASEH = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_SIZE  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_TAIL  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_WBL   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_WBH   = 8'h24;
  localparam logic [REG_AW-1:0] OFS_DLY   = 8'h28;
  localparam logic [REG_AW-1:0] OFS_PYLD  = 8'h44;
  localparam logic [REG_AW-1:0] OFS_QRST  = 8'h48;

  typedef struct packed {
    logic fetchAdv;
    logic headAdv;
    logic clearAll;
  } ringStrobe_t;
endpackage

// File: rtl/desc_ring_dp.sv
module desc_ring_dp
  import desc_ring_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int DLY_W     = 16,
  parameter int DESC_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  ringStrobe_t       stb,
  output logic              qEnable,
  output logic              wbEnable,
  output logic              irqEnable,
  output logic              rstReq,
  output logic              fetchPending,
  output logic              drained,
  output logic              ringFull,
  output logic [63:0]       fetchAddr,
  output logic [63:0]       wbAddr,
  output logic [IDX_W-1:0]  head,
  output logic [DLY_W-1:0]  batchDelay
);
  logic [2:0]       ctrlBits;
  logic [31:0]      baseLo, baseHi, wbLo, wbHi, pyldCnt;
  logic [IDX_W:0]   sizeReg;
  logic [IDX_W-1:0] tail, fetchPtr, idxMask, tailInc;
  logic             qRstFlag;

  // power-of-two ring: low bits of size minus one give the wrap mask
  assign idxMask   = sizeReg[IDX_W-1:0] - 1'b1;
  assign tailInc   = tail + 1'b1;
  assign qEnable   = ctrlBits[0];
  assign wbEnable  = ctrlBits[1];
  assign irqEnable = ctrlBits[2];
  assign rstReq    = regWr && (regAddr == OFS_QRST) && regWrData[0];
  assign fetchPending = (fetchPtr != tail);
  assign drained   = (head == tail);
  assign ringFull  = ((tailInc & idxMask) == head);
  assign fetchAddr = {baseHi, baseLo} + (64'(fetchPtr) << DESC_LOG2);
  assign wbAddr    = {wbHi, wbLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBits <= '0; baseLo <= '0; baseHi <= '0; sizeReg <= '0;
      tail <= '0; wbLo <= '0; wbHi <= '0; batchDelay <= '0;
      pyldCnt <= '0; qRstFlag <= 1'b0; fetchPtr <= '0; head <= '0;
    end else begin
      qRstFlag <= 1'b0;
      if (stb.clearAll) begin
        ctrlBits <= '0;
        tail     <= '0;
        fetchPtr <= '0;
        head     <= '0;
        qRstFlag <= 1'b1;
      end else begin
        if (regWr) begin
          case (regAddr)
            OFS_CTRL:  ctrlBits   <= regWrData[2:0];
            OFS_BASEL: baseLo     <= regWrData;
            OFS_BASEH: baseHi     <= regWrData;
            OFS_SIZE:  sizeReg    <= regWrData[IDX_W:0];
            OFS_TAIL:  tail       <= regWrData[IDX_W-1:0] & idxMask;
            OFS_WBL:   wbLo       <= regWrData;
            OFS_WBH:   wbHi       <= regWrData;
            OFS_DLY:   batchDelay <= regWrData[DLY_W-1:0];
            OFS_PYLD:  pyldCnt    <= regWrData;
            default: ;
          endcase
        end
        if (stb.fetchAdv) fetchPtr <= (fetchPtr + 1'b1) & idxMask;
        if (stb.headAdv)  head     <= (head + 1'b1) & idxMask;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFS_CTRL:  rdData = {29'd0, ctrlBits};
      OFS_BASEL: rdData = baseLo;
      OFS_BASEH: rdData = baseHi;
      OFS_SIZE:  rdData = 32'(sizeReg);
      OFS_TAIL:  rdData = 32'(tail);
      OFS_WBL:   rdData = wbLo;
      OFS_WBH:   rdData = wbHi;
      OFS_DLY:   rdData = 32'(batchDelay);
      OFS_PYLD:  rdData = pyldCnt;
      OFS_QRST:  rdData = {31'd0, qRstFlag};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qEnable,
  input  logic             wbEnable,
  input  logic             irqEnable,
  input  logic             rstReq,
  input  logic             fetchPending,
  input  logic             drained,
  input  logic [IDX_W-1:0] head,
  input  logic [DLY_W-1:0] batchDelay,
  input  logic             fetchReady,
  input  logic             cplValid,
  input  logic             cplIrqEn,
  input  logic             cplWbEn,
  input  logic             wbReady,
  output ringStrobe_t      stb,
  output logic             fetchValid,
  output logic             cplReady,
  output logic             irqReq,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbData
);
  logic             dirty, flushNow, cplFire;
  logic [DLY_W-1:0] batchCnt;

  // launch a merged writeback when the window expires or the ring drains
  assign flushNow   = dirty && !wbValid && ((batchCnt >= batchDelay) || drained);
  assign fetchValid = qEnable && fetchPending && !rstReq;
  assign cplReady   = !wbValid && !flushNow && !rstReq;
  assign cplFire    = cplValid && cplReady;

  always_comb begin
    stb.fetchAdv = fetchValid && fetchReady;
    stb.headAdv  = cplFire;
    stb.clearAll = rstReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirty <= 1'b0; batchCnt <= '0; wbValid <= 1'b0;
      wbData <= '0; irqReq <= 1'b0;
    end else if (rstReq) begin
      dirty <= 1'b0; batchCnt <= '0; wbValid <= 1'b0; irqReq <= 1'b0;
    end else begin
      irqReq <= cplFire && irqEnable && cplIrqEn;
      if (wbValid && wbReady) wbValid <= 1'b0;
      if (flushNow) begin
        wbValid  <= 1'b1;
        wbData   <= head;
        dirty    <= 1'b0;
        batchCnt <= '0;
      end else if (dirty) begin
        batchCnt <= batchCnt + 1'b1;
      end
      if (cplFire && wbEnable && cplWbEn) dirty <= 1'b1;
    end
  end
endmodule

// File: rtl/desc_ring_ctl.sv
module desc_ring_ctl
  import desc_ring_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int DLY_W     = 16,
  parameter int DESC_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  logic [7:0]       regRdAddr,
  output logic [31:0]      regRdData,
  output logic             fetchValid,
  input  logic             fetchReady,
  output logic [63:0]      fetchAddr,
  input  logic             cplValid,
  output logic             cplReady,
  input  logic             cplIrqEn,
  input  logic             cplWbEn,
  output logic             irqReq,
  output logic             wbValid,
  input  logic             wbReady,
  output logic [63:0]      wbAddr,
  output logic [IDX_W-1:0] wbData,
  output logic             ringFull
);
  ringStrobe_t      stb;
  logic             qEnable, wbEnable, irqEnable, rstReq, fetchPending, drained;
  logic [IDX_W-1:0] head;
  logic [DLY_W-1:0] batchDelay;

  desc_ring_dp #(.IDX_W(IDX_W), .DLY_W(DLY_W), .DESC_LOG2(DESC_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .rdAddr(regRdAddr), .rdData(regRdData),
    .stb(stb), .qEnable(qEnable), .wbEnable(wbEnable), .irqEnable(irqEnable),
    .rstReq(rstReq), .fetchPending(fetchPending), .drained(drained),
    .ringFull(ringFull), .fetchAddr(fetchAddr), .wbAddr(wbAddr),
    .head(head), .batchDelay(batchDelay)
  );

  desc_ring_ctrl #(.IDX_W(IDX_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .qEnable(qEnable), .wbEnable(wbEnable),
    .irqEnable(irqEnable), .rstReq(rstReq), .fetchPending(fetchPending),
    .drained(drained), .head(head), .batchDelay(batchDelay),
    .fetchReady(fetchReady), .cplValid(cplValid), .cplIrqEn(cplIrqEn),
    .cplWbEn(cplWbEn), .wbReady(wbReady), .stb(stb), .fetchValid(fetchValid),
    .cplReady(cplReady), .irqReq(irqReq), .wbValid(wbValid), .wbData(wbData)
  );
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic             qEnable,
  input logic             rstReq,
  input logic             cplValid,
  input logic             cplReady,
  input logic             cplIrqEn,
  input logic             irqReq,
  input logic             wbValid,
  input logic             wbReady,
  input logic [IDX_W-1:0] wbData
);
  // R4
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> qEnable);

  // R5
  cpl_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !cplReady);

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady && !rstReq) |=> (wbValid && $stable(wbData)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(cplValid && cplReady && cplIrqEn));

  // R11
  qrst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> (!fetchValid && !wbValid && !irqReq));
endmodule

bind desc_ring_ctl desc_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .qEnable(qEnable),
  .rstReq(rstReq), .cplValid(cplValid), .cplReady(cplReady),
  .cplIrqEn(cplIrqEn), .irqReq(irqReq), .wbValid(wbValid),
  .wbReady(wbReady), .wbData(wbData)
);

// File: tb/desc_ring_ctl_bench.sv
module desc_ring_ctl_bench;
  localparam int IDX_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic regWr = 1'b0;
  logic [7:0] regAddr = '0, regRdAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic fetchValid, fetchReady = 1'b0;
  logic [63:0] fetchAddr, wbAddr;
  logic cplValid = 1'b0, cplReady, cplIrqEn = 1'b0, cplWbEn = 1'b0;
  logic irqReq, wbValid, wbReady = 1'b0, ringFull;
  logic [IDX_W-1:0] wbData;

  int checks = 0, errors = 0, fetchCnt = 0, wbCnt = 0, cyc = 0, wbStart = 0;

  desc_ring_ctl u_desc_ring_ctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchAddr(fetchAddr),
    .cplValid(cplValid), .cplReady(cplReady), .cplIrqEn(cplIrqEn),
    .cplWbEn(cplWbEn), .irqReq(irqReq), .wbValid(wbValid), .wbReady(wbReady),
    .wbAddr(wbAddr), .wbData(wbData), .ringFull(ringFull)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference state
  bit mEn, mWbE, mIrqE, mDirty, mWbV, mIrq;
  logic [63:0] mBase, mWbAddr;
  int mSize, mTail, mFetch, mHead, mDelay, mCnt, mWbD;
  bit pClr, pFF, pCF, pFL;

  function automatic int mMask();
    return ((mSize & 255) - 1) & 255;
  endfunction
  function automatic bit clrNow();
    return regWr && (regAddr == 8'h48) && regWrData[0];
  endfunction
  function automatic bit eFV();
    return mEn && (mFetch != mTail) && !clrNow();
  endfunction
  function automatic bit eFlush();
    return mDirty && !mWbV && ((mCnt >= mDelay) || (mHead == mTail));
  endfunction
  function automatic bit eCplRdy();
    return !mWbV && !eFlush() && !clrNow();
  endfunction
  function automatic logic [63:0] eAddr();
    return mBase + 64'(mFetch) * 64'd32;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mWbE = 0; mIrqE = 0; mDirty = 0; mWbV = 0; mIrq = 0;
      mBase = '0; mWbAddr = '0; mSize = 0; mTail = 0; mFetch = 0;
      mHead = 0; mDelay = 0; mCnt = 0; mWbD = 0;
    end else begin
      pClr = clrNow(); pFF = eFV() && fetchReady;
      pCF = cplValid && eCplRdy(); pFL = eFlush();
      if (pClr) begin
        mEn = 0; mWbE = 0; mIrqE = 0; mTail = 0; mFetch = 0; mHead = 0;
        mDirty = 0; mCnt = 0; mWbV = 0; mIrq = 0;
      end else begin
        mIrq = pCF && mIrqE && cplIrqEn;
        if (mWbV && wbReady) mWbV = 0;
        if (pFL) begin mWbV = 1; mWbD = mHead; mDirty = 0; mCnt = 0; end
        else if (mDirty) mCnt++;
        if (pCF && mWbE && cplWbEn) mDirty = 1;
        if (pFF) mFetch = (mFetch + 1) & mMask();
        if (pCF) mHead = (mHead + 1) & mMask();
        if (regWr) begin
          case (regAddr)
            8'h00: begin mEn = regWrData[0]; mWbE = regWrData[1]; mIrqE = regWrData[2]; end
            8'h08: mBase[31:0] = regWrData;
            8'h0C: mBase[63:32] = regWrData;
            8'h10: mSize = int'(regWrData[8:0]);
            8'h14: mTail = int'(regWrData[7:0]) & mMask();
            8'h20: mWbAddr[31:0] = regWrData;
            8'h24: mWbAddr[63:32] = regWrData;
            8'h28: mDelay = int'(regWrData[15:0]);
            default: ;
          endcase
        end
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      check(fetchValid === eFV(), "R3 fetchValid", longint'(fetchValid), longint'(eFV()));
      if (eFV()) check(fetchAddr === eAddr(), "R3 fetchAddr", fetchAddr, eAddr());
      check(cplReady === eCplRdy(), "R5 cplReady", longint'(cplReady), longint'(eCplRdy()));
      check(irqReq === mIrq, "R6 irqReq", longint'(irqReq), longint'(mIrq));
      check(wbValid === mWbV, "R7 wbValid", longint'(wbValid), longint'(mWbV));
      if (mWbV) begin
        check(wbData === IDX_W'(mWbD), "R8 wbData", longint'(wbData), longint'(mWbD));
        check(wbAddr === mWbAddr, "R7 wbAddr", wbAddr, mWbAddr);
      end
      check(ringFull === (((mTail + 1) & mMask()) == mHead), "R10 ringFull",
            longint'(ringFull), longint'(((mTail + 1) & mMask()) == mHead));
    end
  end

  // ready patterns and handshake counters
  initial forever begin
    @(negedge clk);
    cyc++;
    fetchReady = (cyc % 3 != 0);
    wbReady = (cyc % 4 != 1);
    #1;
    if (rstN && fetchValid && fetchReady) fetchCnt++;
    if (rstN && wbValid && wbReady) wbCnt++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    regRdAddr = a;
    #1;
    check(regRdData === exp, req, longint'(regRdData), longint'(exp));
  endtask

  task automatic cpl(input bit irq, input bit wb);
    @(negedge clk);
    cplValid = 1'b1; cplIrqEn = irq; cplWbEn = wb;
    #1;
    while (!cplReady) begin @(negedge clk); #1; end
    @(negedge clk);
    cplValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(fetchValid === 1'b0, "R1 fetchValid", longint'(fetchValid), 0);
    check(wbValid === 1'b0, "R1 wbValid", longint'(wbValid), 0);
    check(irqReq === 1'b0, "R1 irqReq", longint'(irqReq), 0);
    rd(8'h00, 32'h0, "R1 control");
    rd(8'h14, 32'h0, "R1 tail");

    wr(8'h08, 32'h1000_0040); wr(8'h0C, 32'h1); wr(8'h10, 32'd8);
    wr(8'h20, 32'hABCD_0000); wr(8'h24, 32'h2); wr(8'h28, 32'd0); wr(8'h44, 32'd64);
    rd(8'h08, 32'h1000_0040, "R2 base low");
    rd(8'h0C, 32'h1, "R2 base high");
    rd(8'h10, 32'd8, "R2 size");
    rd(8'h24, 32'h2, "R2 wb high");
    rd(8'h44, 32'd64, "R2 payload count");

    wr(8'h14, 32'd3);
    repeat (5) @(negedge clk); #1;
    check(fetchCnt == 0, "R4 no fetch while disabled", fetchCnt, 0);
    rd(8'h14, 32'd3, "R4 tail latched");
    wr(8'h00, 32'h7);
    rd(8'h00, 32'h7, "R2 control");
    repeat (20) @(negedge clk); #1;
    check(fetchCnt == 3, "R4 latched tail served", fetchCnt, 3);
    check(fetchValid === 1'b0, "R3 stop at tail", longint'(fetchValid), 0);

    wr(8'h14, 32'd7); wr(8'h14, 32'd2);
    repeat (30) @(negedge clk); #1;
    check(fetchCnt == 10, "R3 wrap fetch count", fetchCnt, 10);

    cpl(1, 1); cpl(0, 0); cpl(1, 1);
    repeat (10) @(negedge clk); #1;
    check(wbCnt == 2, "R7 writeback count", wbCnt, 2);

    wbStart = wbCnt;
    wr(8'h28, 32'd20);
    cpl(1, 1); cpl(1, 1); cpl(0, 1); cpl(1, 1);
    repeat (30) @(negedge clk); #1;
    check(wbCnt - wbStart == 1, "R8 merged writebacks", wbCnt - wbStart, 1);
    check(wbData === 8'd7, "R8 latest head", longint'(wbData), 7);

    wbStart = wbCnt;
    wr(8'h28, 32'd1000);
    cpl(0, 1); cpl(0, 1); cpl(1, 1);
    repeat (10) @(negedge clk); #1;
    check(wbCnt - wbStart == 1, "R9 drain flush", wbCnt - wbStart, 1);
    check(wbData === 8'd2, "R9 drained head", longint'(wbData), 2);

    check(ringFull === 1'b0, "R10 not full", longint'(ringFull), 0);
    wr(8'h14, 32'd1); #1;
    check(ringFull === 1'b1, "R10 full", longint'(ringFull), 1);

    regRdAddr = 8'h48;
    wr(8'h48, 32'h1); #1;
    check(regRdData === 32'h1, "R11 reset reads 1", longint'(regRdData), 1);
    @(negedge clk); #1;
    check(regRdData === 32'h0, "R11 reset self-clears", longint'(regRdData), 0);
    rd(8'h14, 32'h0, "R11 tail cleared");
    rd(8'h00, 32'h0, "R11 control cleared");
    wr(8'h14, 32'd3);
    repeat (5) @(negedge clk); #1;
    check(fetchValid === 1'b0, "R11 queue left disabled", longint'(fetchValid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule